// File: doc/BRIEF.md
# Two-Operand ALU with Flag Register and Branch Test

This block executes two-operand integer operations in which the destination is also the first source. Operand A carries the current value of the destination. Operand B carries the second source, which may come from a register, from memory or from an immediate field. The block computes A op B and offers the result together with a write-back enable, so that the surrounding datapath writes the result over the destination. Operand fetch, the register file and program-counter update are outside the block.

Every legal operation updates a four-bit status register as a side effect. The register holds the sign, overflow, zero and carry bits. The update takes effect on the clock edge on which the operation is presented with `op_valid` high. At all other times the flags keep their value. A compare operation changes only the flags and does not request a write-back.

A branch evaluator reads the registered flags combinationally. A three-bit condition code selects one flag and states whether the branch is taken when that flag is set or when it is clear.

Top module: `alu2op_core`

## Requirements
- R1: Opcode 0 (ADD) drives `result` = A + B modulo 2^32 in the same cycle, and `wb_en` equals `op_valid`.
- R2: Opcode 1 (SUB) drives `result` = A - B modulo 2^32 in the same cycle, and `wb_en` equals `op_valid`.
- R3: Opcodes 2, 3 and 4 (AND, OR, XOR) drive the bitwise AND, OR and XOR of A and B. They request write-back, and they clear flag bits C (bit 0) and O (bit 2).
- R4: Opcode 5 (CMP) updates the flags exactly as SUB would, and it keeps `wb_en` low.
- R5: After a clock edge with `op_valid` high and a legal opcode, flag bit S (bit 3) equals the MSB of that cycle's result, and flag bit Z (bit 1) is 1 exactly when that result is zero.
- R6: For ADD, SUB and CMP, flag bit O is set when the operation gives a signed two's-complement overflow.
- R7: For ADD, flag bit C is the carry out of bit 31. For SUB and CMP, C is the borrow, meaning it is 1 when A < B as unsigned numbers.
- R8: The flags hold their value across any edge on which `op_valid` is low, or on which the opcode is 6 or 7. `wb_en` stays low in those cases.
- R9: `take_branch` is combinational from the registered flags. `cond_sel[2:1]` selects the flag (0=S, 1=O, 2=Z, 3=C). `cond_sel[0]`=0 means the branch is taken when that flag is 1, and `cond_sel[0]`=1 means it is taken when that flag is 0.
- R10: While `rst_n` is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented; enables the flag update |
| opcode | input | 3 | Operation select |
| opnd_a | input | 32 | Destination value, first source |
| opnd_b | input | 32 | Second source (register, memory or immediate) |
| result | output | 32 | Operation result |
| wb_en | output | 1 | Request to write `result` over the destination |
| flags | output | 4 | Registered flags {S, O, Z, C} |
| cond_sel | input | 3 | Branch condition code |
| take_branch | output | 1 | Branch decision |

## Verification
The properties assume that `op_valid`, `opcode` and both operands are stable around the sampling edge. They also assume that a flag-update cycle is preceded by at least one clock out of reset, so that the `$past` values refer to a real operation. The bench drives every input on the falling edge and starts operations only after reset has been released for a full cycle. Each operation is held for exactly one rising edge, and `op_valid` returns low before the next operation is set up.

// File: rtl/alu2op_pkg.sv
package alu2op_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 3;
    localparam int COND_W = 3;
    localparam int FLAG_N = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_CMP = 3'd5,
        OP_RS6 = 3'd6,
        OP_RS7 = 3'd7
    } opcode_e;

    // packed order puts sign in bit 3 and carry in bit 0
    typedef struct packed {
        logic s;
        logic o;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        SEL_S = 2'd0,
        SEL_O = 2'd1,
        SEL_Z = 2'd2,
        SEL_C = 2'd3
    } flag_sel_e;

endpackage

// File: rtl/alu2op_exec.sv
module alu2op_exec
    import alu2op_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    res,
    output flags_t          fl,
    output logic            writes,
    output logic            legal
);
    localparam int MSB = W - 1;

    opcode_e     op_e;
    logic        is_sub;
    logic        is_arith;
    logic [W-1:0] b_eff;
    logic [W:0]   sum_ext;
    logic [W-1:0] logic_res;
    logic        ovf;

    assign op_e = opcode_e'(op);

    always_comb begin
        is_sub   = (op_e == OP_SUB) || (op_e == OP_CMP);
        is_arith = is_sub || (op_e == OP_ADD);
        legal    = (op_e != OP_RS6) && (op_e != OP_RS7);
        writes   = legal && (op_e != OP_CMP);
    end

    // one adder serves both add and subtract: B is inverted and the carry-in is set
    always_comb begin
        b_eff   = is_sub ? ~b : b;
        sum_ext = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
        ovf     = (a[MSB] == b_eff[MSB]) && (sum_ext[MSB] != a[MSB]);
    end

    always_comb begin
        unique case (op_e)
            OP_AND:  logic_res = a & b;
            OP_OR:   logic_res = a | b;
            OP_XOR:  logic_res = a ^ b;
            default: logic_res = '0;
        endcase
    end

    always_comb begin
        res  = is_arith ? sum_ext[W-1:0] : logic_res;
        fl.s = res[MSB];
        fl.z = (res == '0);
        fl.o = is_arith ? ovf : 1'b0;
        // carry out for add, inverted carry (borrow) for subtract
        fl.c = is_arith ? (sum_ext[W] ^ is_sub) : 1'b0;
    end

endmodule

// File: rtl/alu2op_cond.sv
module alu2op_cond
    import alu2op_pkg::*;
(
    input  flags_t            fl,
    input  logic [COND_W-1:0] cond,
    output logic              taken
);
    flag_sel_e sel;
    logic      picked;

    assign sel = flag_sel_e'(cond[COND_W-1:1]);

    always_comb begin
        unique case (sel)
            SEL_S:   picked = fl.s;
            SEL_O:   picked = fl.o;
            SEL_Z:   picked = fl.z;
            default: picked = fl.c;
        endcase
        taken = picked ^ cond[0];
    end

endmodule

// File: rtl/alu2op_core.sv
module alu2op_core
    import alu2op_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    output logic [W-1:0]      result,
    output logic              wb_en,
    output logic [FLAG_N-1:0] flags,
    input  logic [COND_W-1:0] cond_sel,
    output logic              take_branch
);
    typedef struct packed {
        flags_t fl;
    } core_state_t;

    core_state_t state_d, state_q;
    flags_t      exec_fl;
    logic        exec_writes;
    logic        exec_legal;

    alu2op_exec #(.W(W)) u_exec (
        .op     (opcode),
        .a      (opnd_a),
        .b      (opnd_b),
        .res    (result),
        .fl     (exec_fl),
        .writes (exec_writes),
        .legal  (exec_legal)
    );

    always_comb begin
        state_d = state_q;
        if (op_valid && exec_legal) begin
            state_d.fl = exec_fl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wb_en = op_valid && exec_writes;
    assign flags = state_q.fl;

    alu2op_cond u_cond (
        .fl    (state_q.fl),
        .cond  (cond_sel),
        .taken (take_branch)
    );

endmodule

// File: rtl/alu2op_checker.sv
module alu2op_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [2:0]   opcode,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic         wb_en,
    input logic [3:0]   flags,
    input logic [2:0]   cond_sel,
    input logic         take_branch
);
    logic upd;
    assign upd = op_valid && (opcode <= 3'd5);

    p_add_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 3'd0) |-> (result == opnd_a + opnd_b) && wb_en);

    p_sub_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 3'd1) |-> (result == opnd_a - opnd_b) && wb_en);

    p_logic_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode >= 3'd2 && opcode <= 3'd4) |=> (flags[2] == 1'b0 && flags[0] == 1'b0));

    p_cmp_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 3'd5) |-> !wb_en);

    p_sign_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (flags[3] == $past(result[W-1])) && (flags[1] == ($past(result) == '0)));

    p_add_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 3'd0) |=> flags[2] ==
            (($past(opnd_a[W-1]) == $past(opnd_b[W-1])) && ($past(result[W-1]) != $past(opnd_a[W-1]))));

    p_add_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 3'd0) |=> flags[0] == ($past(result) < $past(opnd_a)));

    p_sub_borrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode == 3'd1 || opcode == 3'd5)) |=> flags[0] == ($past(opnd_a) < $past(opnd_b)));

    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flags));

    p_no_wb_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || opcode >= 3'd6) |-> !wb_en);

    p_branch_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_branch == (flags[2'd3 - cond_sel[2:1]] ^ cond_sel[0]));

    always_comb begin
        if (!rst_n) begin
            p_reset_clear_r10: assert (flags == 4'b0000);
        end
    end

endmodule

bind alu2op_core alu2op_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .opcode      (opcode),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .result      (result),
    .wb_en       (wb_en),
    .flags       (flags),
    .cond_sel    (cond_sel),
    .take_branch (take_branch)
);

// File: tb/alu2op_core_test.sv
`timescale 1ns/1ps
module alu2op_core_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  opcode;
    logic [31:0] opnd_a, opnd_b;
    logic [31:0] result;
    logic        wb_en;
    logic [3:0]  flags;
    logic [2:0]  cond_sel;
    logic        take_branch;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] model_fl = 4'b0000;

    always #2.5 clk = ~clk;

    alu2op_core uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .wb_en(wb_en),
        .flags(flags), .cond_sel(cond_sel), .take_branch(take_branch)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // independent reference: result, flags {S,O,Z,C}, write-back, legal
    task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic [3:0] f,
                         output logic wb, output logic legal);
        logic [32:0] wide;
        logic o, c;
        o = 1'b0; c = 1'b0; r = '0;
        legal = (op <= 3'd5);
        wb    = legal && (op != 3'd5);
        case (op)
            3'd0: begin
                wide = {1'b0, a} + {1'b0, b}; r = wide[31:0]; c = wide[32];
                o = ($signed(a) >= 0) == ($signed(b) >= 0) && (($signed(r) >= 0) != ($signed(a) >= 0));
            end
            3'd1, 3'd5: begin
                r = a - b; c = (a < b);
                o = (($signed(a) >= 0) != ($signed(b) >= 0)) && (($signed(r) >= 0) != ($signed(a) >= 0));
            end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            default: r = '0;
        endcase
        f = {r[31], o, (r == 32'd0), c};
    endtask

    task automatic run_op(input logic vld, input logic [2:0] op,
                          input logic [31:0] a, input logic [31:0] b, input string req);
        logic [31:0] er; logic [3:0] ef; logic ewb, leg;
        model(op, a, b, er, ef, ewb, leg);
        @(negedge clk);
        op_valid = vld; opcode = op; opnd_a = a; opnd_b = b;
        #1;
        if (op <= 3'd4) check({req, " result"}, result, er);
        check({req, " wb_en"}, {31'd0, wb_en}, {31'd0, vld && ewb});
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        if (vld && leg) model_fl = ef;
        check({req, " flags"}, {28'd0, flags}, {28'd0, model_fl});
    endtask

    task automatic t_reset;
        rst_n = 1'b0; op_valid = 1'b0; opcode = '0; opnd_a = '0; opnd_b = '0; cond_sel = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 flags in reset", {28'd0, flags}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R10 flags after reset", {28'd0, flags}, 32'd0);
    endtask

    task automatic t_add;
        run_op(1, 3'd0, 32'h0000_0005, 32'h0000_0007, "R1 plain add");
        run_op(1, 3'd0, 32'h7FFF_FFFF, 32'h0000_0001, "R6 add signed overflow");
        run_op(1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, "R7 add carry to zero R5");
        run_op(1, 3'd0, 32'h8000_0000, 32'h8000_0000, "R6 R7 add neg overflow");
        run_op(1, 3'd0, 32'hFFFF_FFF0, 32'h0000_0002, "R5 add negative");
    endtask

    task automatic t_sub;
        run_op(1, 3'd1, 32'h8000_0000, 32'h0000_0001, "R6 sub overflow");
        run_op(1, 3'd1, 32'h0000_0001, 32'h0000_0002, "R7 sub borrow");
        run_op(1, 3'd1, 32'h1234_5678, 32'h1234_5678, "R2 R5 sub to zero");
        run_op(1, 3'd1, 32'h0000_0100, 32'h0000_0010, "R2 sub plain");
    endtask

    task automatic t_logic;
        run_op(1, 3'd0, 32'h7FFF_FFFF, 32'h0000_0001, "R6 set O before logic");
        run_op(1, 3'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, "R3 and");
        run_op(1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0002, "R7 set C before logic");
        run_op(1, 3'd3, 32'h0000_0000, 32'h0000_0000, "R3 or zero");
        run_op(1, 3'd4, 32'hAAAA_AAAA, 32'h5555_5555, "R3 xor");
    endtask

    task automatic t_cmp;
        run_op(1, 3'd5, 32'h0000_0003, 32'h0000_0009, "R4 cmp less");
        run_op(1, 3'd5, 32'h8000_0000, 32'h0000_0001, "R4 cmp overflow");
        run_op(1, 3'd5, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R4 cmp equal");
    endtask

    task automatic t_hold;
        run_op(1, 3'd1, 32'h0000_0000, 32'h0000_0001, "R8 set flags");
        run_op(0, 3'd0, 32'h0000_0000, 32'h0000_0000, "R8 idle holds");
        run_op(1, 3'd6, 32'h0000_0000, 32'h0000_0000, "R8 opcode 6 holds");
        run_op(1, 3'd7, 32'h7FFF_FFFF, 32'h0000_0001, "R8 opcode 7 holds");
    endtask

    task automatic check_branches(input string req);
        for (int k = 0; k < 8; k++) begin
            logic exp;
            @(negedge clk);
            cond_sel = 3'(k);
            #1;
            exp = model_fl[3 - (k >> 1)] ^ k[0];
            check({req, " take_branch"}, {31'd0, take_branch}, {31'd0, exp});
        end
    endtask

    task automatic t_branch;
        run_op(1, 3'd0, 32'h7FFF_FFFF, 32'h0000_0001, "R9 prep S O");
        check_branches("R9 S O set");
        run_op(1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, "R9 prep Z C");
        check_branches("R9 Z C set");
        run_op(1, 3'd3, 32'h0000_0001, 32'h0000_0000, "R9 prep clear");
        check_branches("R9 all clear");
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset;
        t_add;
        t_sub;
        t_logic;
        t_cmp;
        t_hold;
        t_branch;
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule